// File: doc/BRIEF.md
# Endpoint FIFO Double-Buffer Pairing Steering

This block lets a USB device controller double buffer bulk traffic by joining two endpoint FIFOs into one logical buffer. Endpoints 1 and 2 form one pair and endpoints 3 and 4 form another. Each pair can be joined separately for the IN direction and for the OUT direction, so four enable bits are held in a pairing control register. A second register holds the 7-bit device address. Both registers are written and read over a simple CPU register bus. A strobe from the USB side also clears the device address when a bus reset is seen.

When a pair is joined, the CPU reaches the pair only through its odd endpoint. The block steers that access to whichever FIFO of the pair is active. Each write of the packet-size register through the odd endpoint swaps the active side. The USB engine is always given the other FIFO of the pair, so the CPU fills or drains one packet while the other one moves on the bus. FIFO storage and the serial engine sit outside this block. Each side sees a one-hot physical FIFO select, in which bit i stands for the FIFO of endpoint i.

Top module: `usb_ep_pair_steer`

## Requirements
- R1: After reset both registers read 0x00, no pair is joined, and every endpoint maps one to one on the CPU and USB selects.
- R2: The pairing register is at address 0xE3. Bit 0 joins the IN FIFOs of endpoints 1/2, bit 1 the IN FIFOs of 3/4, bit 2 the OUT FIFOs of 1/2, and bit 3 the OUT FIFOs of 3/4. Bits 7:4 ignore writes and read as 0.
- R3: The device address register is at address 0xE2. Bits 6:0 hold the address, which also drives `dev_addr`. Bit 7 ignores writes and reads as 0.
- R4: A `usb_bus_rst` pulse clears the device address in the next cycle. It takes priority over a register write in the same cycle.
- R5: While a direction of a pair is not joined, its endpoints map one to one (select bit equal to endpoint number), and packet-size writes do not change any select.
- R6: When a pair is joined, the active side starts at the odd FIFO. A CPU access through the odd endpoint selects the active FIFO.
- R7: A packet-size write (`cpu_size_wr`) through the odd endpoint of a joined pair, in the matching direction, swaps the active side from the next cycle on.
- R8: For a joined pair, a USB access through either endpoint of the pair selects the FIFO that is not active.
- R9: A CPU access through the even endpoint of a joined pair selects no FIFO (all select bits 0).
- R10: A packet-size write through the even endpoint of a joined pair is ignored, and the active side stays the same.
- R11: Clearing a pair's enable bit returns its active side to the odd FIFO. A later re-enable therefore starts from the odd FIFO.
- R12: The four pairings are independent. Swapping or enabling one never changes the select of another pair or the other direction.
- R13: Writes to register addresses other than 0xE2 and 0xE3 are ignored, and such addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | CPU register address |
| reg_wdata | input | 8 | CPU register write data |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| usb_bus_rst | input | 1 | USB bus reset detected, one-cycle pulse |
| dev_addr | output | 7 | Current device address |
| cpu_ep | input | 3 | Endpoint number of the CPU FIFO access |
| cpu_dir | input | 1 | Direction of the CPU access: 0 IN, 1 OUT |
| cpu_size_wr | input | 1 | Packet-size register written for `cpu_ep`/`cpu_dir` |
| cpu_fifo_sel | output | 5 | One-hot physical FIFO for the CPU access |
| usb_ep | input | 3 | Endpoint number served by the USB engine |
| usb_dir | input | 1 | Direction of the USB access: 0 IN, 1 OUT |
| usb_fifo_sel | output | 5 | One-hot physical FIFO for the USB access |

## Verification
The in-line assertions check the following on every cycle. Each toggle flop clears while its pair is disabled, flips on a qualifying size write and holds otherwise. A bus reset zeroes the address. The pairing register changes only on a write to its own address. Both selects are at most one-hot. The CPU and USB never share a FIFO when both work on the same joined pair. The directed scenarios cover the rest: the register bit positions and reserved bits, the identity mapping while unpaired, the dead even endpoint, the ignored even-endpoint size write, independence across pairs and directions, and the restart from the odd FIFO after a disable.

// File: rtl/ep_pair_pkg.sv
// Shared sizing for the endpoint pairing steering block.
// Assumes endpoint 0 is never paired and pairs are (1,2), (3,4), ...
package ep_pair_pkg;
    localparam int NUM_PAIRS  = 2;
    localparam int EP_COUNT   = 2 * NUM_PAIRS + 1;
    localparam int EP_W       = $clog2(EP_COUNT);
    localparam int CTRL_W     = 2 * NUM_PAIRS;
    localparam int DATA_W     = 8;
    localparam int RADDR_W    = 8;
    localparam int DEV_ADDR_W = 7;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } ep_dir_e;

    // Control bit index for direction d and pair p: IN pairs first, then OUT.
    function automatic int ctrl_idx(input int d, input int p);
        return d * NUM_PAIRS + p;
    endfunction
endpackage

// File: rtl/ep_pair_regs.sv
// Pairing-enable and device-address registers on the CPU register bus.
// Assumes single-cycle write strobes. Reads are combinational from reg_addr.
// Reserved bits are not stored, so they read as zero.
module ep_pair_regs
    import ep_pair_pkg::*;
#(
    parameter logic [RADDR_W-1:0] CTRL_ADDR  = 8'hE3,
    parameter logic [RADDR_W-1:0] DADDR_ADDR = 8'hE2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  reg_wr,
    input  logic                  bus_rst,
    output logic [CTRL_W-1:0]     pair_en,
    output logic [DEV_ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0]     reg_rdata
);
    logic wr_ctrl;
    logic wr_daddr;
    logic unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == CTRL_ADDR);
    assign wr_daddr     = reg_wr && (reg_addr == DADDR_ADDR);
    assign unused_wbits = ^reg_wdata[DATA_W-1:DEV_ADDR_W];

    // Pairing enables: loaded only by a write to the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_en <= '0;
        else if (wr_ctrl)
            pair_en <= reg_wdata[CTRL_W-1:0];
    end

    // Device address: bus reset wins over a same-cycle CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_addr <= '0;
        else if (bus_rst)
            dev_addr <= '0;
        else if (wr_daddr)
            dev_addr <= reg_wdata[DEV_ADDR_W-1:0];
    end

    // Read mux with zero fill for reserved bits and unmapped addresses.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR)
            reg_rdata = DATA_W'(pair_en);
        else if (reg_addr == DADDR_ADDR)
            reg_rdata = DATA_W'(dev_addr);
    end

    p_bus_rst_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (dev_addr == '0));

    p_ctrl_only_own_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == CTRL_ADDR)) |=> $stable(pair_en));
endmodule

// File: rtl/ep_pair_toggle.sv
// Active-side flop for one pairing (one direction of one endpoint pair).
// 0 selects the odd FIFO and 1 selects the even FIFO. Cleared while disabled.
module ep_pair_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic flip,
    output logic active
);
    // Track the active side: hold at odd when off, swap on each flip.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (!en)
            active <= 1'b0;
        else if (flip)
            active <= ~active;
    end

    p_off_returns_odd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);

    p_flip_swaps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flip) |=> (active != $past(active)));

    p_no_flip_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flip) |=> $stable(active));
endmodule

// File: rtl/ep_pair_route.sv
// Maps a logical endpoint/direction to a one-hot physical FIFO select.
// USB_SIDE=0 gives the CPU view: odd endpoint -> active FIFO, even -> none.
// USB_SIDE=1 gives the engine view: either endpoint -> the inactive FIFO.
// Assumes pairs are (2p+1, 2p+2). Endpoints outside range select nothing.
module ep_pair_route
    import ep_pair_pkg::*;
#(
    parameter bit USB_SIDE = 1'b0
) (
    input  logic [EP_W-1:0]     ep,
    input  logic                dir,
    input  logic [CTRL_W-1:0]   pair_en,
    input  logic [CTRL_W-1:0]   active,
    output logic [EP_COUNT-1:0] sel
);
    // Identity mapping first, then override for any joined pair hit.
    always_comb begin
        sel = '0;
        if (int'(ep) < EP_COUNT)
            sel[ep] = 1'b1;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            int idx;
            logic hit_odd;
            logic hit_even;
            idx      = ctrl_idx(int'(dir), p);
            hit_odd  = (ep == EP_W'(2 * p + 1));
            hit_even = (ep == EP_W'(2 * p + 2));
            if (pair_en[idx] && (hit_odd || hit_even)) begin
                sel = '0;
                if (USB_SIDE) begin
                    if (active[idx])
                        sel[2 * p + 1] = 1'b1;
                    else
                        sel[2 * p + 2] = 1'b1;
                end else if (hit_odd) begin
                    if (active[idx])
                        sel[2 * p + 2] = 1'b1;
                    else
                        sel[2 * p + 1] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/usb_ep_pair_steer.sv
// Top of the endpoint pairing block: registers, one toggle per pairing,
// and separate CPU and USB routing. Assumes cpu_size_wr is a one-cycle
// pulse that names the endpoint and direction on cpu_ep/cpu_dir.
module usb_ep_pair_steer
    import ep_pair_pkg::*;
#(
    parameter logic [RADDR_W-1:0] CTRL_ADDR  = 8'hE3,
    parameter logic [RADDR_W-1:0] DADDR_ADDR = 8'hE2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  reg_wr,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  usb_bus_rst,
    output logic [DEV_ADDR_W-1:0] dev_addr,
    input  logic [EP_W-1:0]       cpu_ep,
    input  logic                  cpu_dir,
    input  logic                  cpu_size_wr,
    output logic [EP_COUNT-1:0]   cpu_fifo_sel,
    input  logic [EP_W-1:0]       usb_ep,
    input  logic                  usb_dir,
    output logic [EP_COUNT-1:0]   usb_fifo_sel
);
    logic [CTRL_W-1:0] pair_en;
    logic [CTRL_W-1:0] active;
    logic [CTRL_W-1:0] flip;

    ep_pair_regs #(
        .CTRL_ADDR  (CTRL_ADDR),
        .DADDR_ADDR (DADDR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .bus_rst   (usb_bus_rst),
        .pair_en   (pair_en),
        .dev_addr  (dev_addr),
        .reg_rdata (reg_rdata)
    );

    for (genvar d = 0; d < 2; d++) begin : g_dir
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam int IDX = d * NUM_PAIRS + p;

            // Only a size write through the odd endpoint swaps the side.
            assign flip[IDX] = cpu_size_wr && (cpu_dir == 1'(d)) &&
                               (cpu_ep == EP_W'(2 * p + 1));

            ep_pair_toggle u_tog (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (pair_en[IDX]),
                .flip   (flip[IDX]),
                .active (active[IDX])
            );

            p_sides_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (pair_en[IDX] && cpu_dir == 1'(d) && usb_dir == 1'(d) &&
                 cpu_ep == EP_W'(2 * p + 1) &&
                 (usb_ep == EP_W'(2 * p + 1) || usb_ep == EP_W'(2 * p + 2)))
                |-> ((cpu_fifo_sel & usb_fifo_sel) == '0));
        end
    end

    ep_pair_route #(.USB_SIDE(1'b0)) u_cpu_route (
        .ep      (cpu_ep),
        .dir     (cpu_dir),
        .pair_en (pair_en),
        .active  (active),
        .sel     (cpu_fifo_sel)
    );

    ep_pair_route #(.USB_SIDE(1'b1)) u_usb_route (
        .ep      (usb_ep),
        .dir     (usb_dir),
        .pair_en (pair_en),
        .active  (active),
        .sel     (usb_fifo_sel)
    );

    p_cpu_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_fifo_sel));

    p_usb_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(usb_fifo_sel));
endmodule

// File: tb/usb_ep_pair_steer_test.sv
`timescale 1ns/1ps
module usb_ep_pair_steer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       usb_bus_rst = 1'b0;
    logic [6:0] dev_addr;
    logic [2:0] cpu_ep = '0;
    logic       cpu_dir = 1'b0;
    logic       cpu_size_wr = 1'b0;
    logic [4:0] cpu_fifo_sel;
    logic [2:0] usb_ep = '0;
    logic       usb_dir = 1'b0;
    logic [4:0] usb_fifo_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep_pair_steer uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .usb_bus_rst(usb_bus_rst), .dev_addr(dev_addr),
        .cpu_ep(cpu_ep), .cpu_dir(cpu_dir), .cpu_size_wr(cpu_size_wr),
        .cpu_fifo_sel(cpu_fifo_sel), .usb_ep(usb_ep), .usb_dir(usb_dir),
        .usb_fifo_sel(usb_fifo_sel)
    );

    localparam logic [7:0] A_CTRL  = 8'hE3;
    localparam logic [7:0] A_DADDR = 8'hE2;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic size_wr(input logic [2:0] ep, input logic dir);
        @(negedge clk);
        cpu_ep = ep; cpu_dir = dir; cpu_size_wr = 1'b1;
        @(negedge clk);
        cpu_size_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic cpu_chk(input logic [2:0] ep, input logic dir, input logic [4:0] exp, input string tag);
        cpu_ep = ep; cpu_dir = dir;
        #1;
        chk(8'(cpu_fifo_sel), 8'(exp), tag);
    endtask

    task automatic usb_chk(input logic [2:0] ep, input logic dir, input logic [4:0] exp, input string tag);
        usb_ep = ep; usb_dir = dir;
        #1;
        chk(8'(usb_fifo_sel), 8'(exp), tag);
    endtask

    task automatic t_reset;
        rd_chk(A_CTRL, 8'h00, "R1 ctrl after reset");
        rd_chk(A_DADDR, 8'h00, "R1 addr after reset");
        cpu_chk(3'd3, 1'b0, 5'b01000, "R1 cpu ep3 IN identity");
        usb_chk(3'd4, 1'b1, 5'b10000, "R1 usb ep4 OUT identity");
    endtask

    task automatic t_regs;
        wr_reg(A_CTRL, 8'hFF);
        rd_chk(A_CTRL, 8'h0F, "R2 reserved ctrl bits zero");
        wr_reg(A_CTRL, 8'h00);
        wr_reg(A_DADDR, 8'hAB);
        rd_chk(A_DADDR, 8'h2B, "R3 addr bit7 reserved");
        chk(8'(dev_addr), 8'h2B, "R3 dev_addr port");
        wr_reg(8'h10, 8'h55);
        rd_chk(8'h10, 8'h00, "R13 unmapped reads zero");
        rd_chk(A_CTRL, 8'h00, "R13 ctrl untouched");
        rd_chk(A_DADDR, 8'h2B, "R13 addr untouched");
    endtask

    task automatic t_bus_rst;
        @(negedge clk);
        usb_bus_rst = 1'b1;
        @(negedge clk);
        usb_bus_rst = 1'b0;
        chk(8'(dev_addr), 8'h00, "R4 bus reset clears");
        @(negedge clk);
        reg_addr = A_DADDR; reg_wdata = 8'h12; reg_wr = 1'b1; usb_bus_rst = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; usb_bus_rst = 1'b0;
        chk(8'(dev_addr), 8'h00, "R4 bus reset beats write");
    endtask

    task automatic t_unpaired;
        size_wr(3'd1, 1'b0);
        cpu_chk(3'd1, 1'b0, 5'b00010, "R5 cpu ep1 unpaired");
        cpu_chk(3'd2, 1'b0, 5'b00100, "R5 cpu ep2 unpaired");
        usb_chk(3'd1, 1'b0, 5'b00010, "R5 usb ep1 unpaired");
        cpu_chk(3'd0, 1'b1, 5'b00001, "R5 cpu ep0");
    endtask

    task automatic t_pair;
        wr_reg(A_CTRL, 8'h01);
        cpu_chk(3'd1, 1'b0, 5'b00010, "R6 starts odd");
        usb_chk(3'd1, 1'b0, 5'b00100, "R8 usb gets even via ep1");
        usb_chk(3'd2, 1'b0, 5'b00100, "R8 usb gets even via ep2");
        size_wr(3'd1, 1'b0);
        cpu_chk(3'd1, 1'b0, 5'b00100, "R7 swap to even");
        usb_chk(3'd2, 1'b0, 5'b00010, "R8 usb gets odd");
        cpu_chk(3'd1, 1'b1, 5'b00010, "R12 OUT direction unaffected");
        cpu_chk(3'd2, 1'b0, 5'b00000, "R9 even endpoint dead");
        size_wr(3'd2, 1'b0);
        cpu_chk(3'd1, 1'b0, 5'b00100, "R10 even size write ignored");
        size_wr(3'd1, 1'b1);
        cpu_chk(3'd1, 1'b0, 5'b00100, "R12 OUT size write leaves IN");
        size_wr(3'd1, 1'b0);
        cpu_chk(3'd1, 1'b0, 5'b00010, "R7 swap back to odd");
    endtask

    task automatic t_indep;
        wr_reg(A_CTRL, 8'h0F);
        size_wr(3'd3, 1'b1);
        cpu_chk(3'd3, 1'b1, 5'b10000, "R7 OUT34 swapped");
        cpu_chk(3'd3, 1'b0, 5'b01000, "R12 IN34 unaffected");
        cpu_chk(3'd1, 1'b1, 5'b00010, "R12 OUT12 unaffected");
        cpu_chk(3'd1, 1'b0, 5'b00010, "R12 IN12 unaffected");
    endtask

    task automatic t_disable;
        wr_reg(A_CTRL, 8'h07);
        cpu_chk(3'd3, 1'b1, 5'b01000, "R5 OUT34 back to identity");
        cpu_chk(3'd4, 1'b1, 5'b10000, "R5 ep4 OUT identity");
        wr_reg(A_CTRL, 8'h0F);
        cpu_chk(3'd3, 1'b1, 5'b01000, "R11 re-enable starts odd");
        usb_chk(3'd3, 1'b1, 5'b10000, "R11 usb gets even after re-enable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_bus_rst();
        t_unpaired();
        t_pair();
        t_indep();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule